// File: doc/BRIEF.md
# Single-Precision Floating-Point Compare Unit

This block compares two 32-bit single-precision floating-point operands and stores the outcome of one selected relation in a one-bit condition flag. The relation can be equal, less-than or less-or-equal. A later branch-style test reads the flag back as either taken-on-true or taken-on-false. The flag changes only on a clock edge where the compare strobe is high. Between compares it keeps its value, so one compare result can serve several later tests.

Most of the work is a plain unsigned integer compare of the exponent and fraction bits. This works because the biased exponent sits above the fraction, so a larger bit pattern means a larger magnitude. Around that core there are sign handling and a set of fix-ups. Subnormal inputs are flushed to a zero of the same sign. The two zeros are treated as equal. Any NaN operand makes every relation false.

Top module: `fcmp_flag_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the flag register is cleared to 0 on that edge.
- R2: The flag takes a new value only at a rising edge where `cmp_valid` is high, and it shows that value after that edge. When `cmp_valid` is low, the flag keeps its value whatever the operands and the select do.
- R3: `cond_sel` encodes the relation tested as a op b: 2'b00 is equal, 2'b01 is less-than, 2'b10 is less-or-equal. 2'b11 is reserved and always writes 0.
- R4: For ordered, nonzero operands, the following rules apply. Two positive values are ordered by their bits [30:0] taken as an unsigned integer. Two negative values are ordered the other way round. Any negative value is less than any positive value.
- R5: +0 (0x00000000) and -0 (0x80000000) compare equal. Neither of them is less than the other.
- R6: An operand whose exponent field (bits [30:23]) is 0 and whose fraction is nonzero is treated as zero. It compares equal to either zero and is less than the smallest positive normal value, 0x00800000.
- R7: An operand whose exponent field is 255 and whose fraction is nonzero is a NaN. A compare with a NaN in either operand writes 0 for every select.
- R8: Exponent 255 with a zero fraction is an infinity. +infinity (0x7F800000) is greater than every finite value, -infinity (0xFF800000) is less than every finite value, and each infinity equals itself.
- R9: `br_take` equals the flag when `br_sense` is 1 and the inverted flag when `br_sense` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Compare strobe; the flag is written on edges where this is high |
| cond_sel | input | 2 | Relation select: 00 equal, 01 less-than, 10 less-or-equal, 11 reserved |
| opa | input | 32 | Left operand a |
| opb | input | 32 | Right operand b |
| br_sense | input | 1 | Branch polarity: 1 takes on a set flag, 0 takes on a clear flag |
| flag | output | 1 | Registered condition flag |
| br_take | output | 1 | Branch decision derived from the flag and the polarity |

## Verification
The operand pairs cover every sign mix: both positive, both negative and opposite signs. This separates a correct reversal for two negatives from a plain integer compare, which would get negative pairs wrong. Signed zeros, subnormals on both sides of zero, and the smallest normal value show whether flushing works and whether the two zeros merge. A naive bit compare fails on both counts. Quiet and minimal-payload NaNs under each select, infinities against the largest finite value, and the reserved select exercise the fix-up paths. Finally, compares with the strobe low and both branch polarities show that the flag is sticky and how it is read back.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  typedef enum logic [1:0] {
    REL_EQ  = 2'b00,
    REL_LT  = 2'b01,
    REL_LE  = 2'b10,
    REL_RSV = 2'b11
  } rel_e;

  typedef struct packed {
    logic neg;
    logic nan;
    logic zero;
  } opclass_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int MAG_W  = EXP_W + FRAC_W,
  localparam int WORD_W = MAG_W + 1
) (
  input  logic [WORD_W-1:0] word_in,
  output opclass_t          cls_out,
  output logic [MAG_W-1:0]  mag_out
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;
  logic              exp_none;

  always_comb begin
    exp_f    = word_in[WORD_W-2 -: EXP_W];
    frac_f   = word_in[FRAC_W-1:0];
    exp_ones = &exp_f;
    exp_none = ~|exp_f;
    cls_out.neg  = word_in[WORD_W-1];
    cls_out.nan  = exp_ones & (|frac_f);
    // subnormals are flushed: any zero exponent counts as zero
    cls_out.zero = exp_none;
    mag_out      = exp_none ? '0 : word_in[MAG_W-1:0];
  end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int MAG_W = 31
) (
  input  opclass_t         cls_a,
  input  opclass_t         cls_b,
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  output logic             rel_eq,
  output logic             rel_lt,
  output logic             unord
);

  logic mag_less;
  logic mag_more;
  logic mag_same;
  logic both_zero;
  logic raw_lt;

  always_comb begin
    mag_less  = mag_a < mag_b;
    mag_more  = mag_b < mag_a;
    mag_same  = mag_a == mag_b;
    both_zero = cls_a.zero & cls_b.zero;
    unord     = cls_a.nan | cls_b.nan;

    if (cls_a.neg != cls_b.neg) raw_lt = cls_a.neg;
    else if (cls_a.neg)         raw_lt = mag_more;
    else                        raw_lt = mag_less;

    rel_eq = ~unord & (both_zero | ((cls_a.neg == cls_b.neg) & mag_same));
    rel_lt = ~unord & ~both_zero & ~rel_eq & raw_lt;
  end

endmodule

// File: rtl/fcmp_flag_reg.sv
module fcmp_flag_reg
  import fcmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load_en,
  input  logic [1:0] sel,
  input  logic       rel_eq,
  input  logic       rel_lt,
  output logic       flag_q
);

  logic pick;

  always_comb begin
    unique case (rel_e'(sel))
      REL_EQ:  pick = rel_eq;
      REL_LT:  pick = rel_lt;
      REL_LE:  pick = rel_lt | rel_eq;
      default: pick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (load_en) flag_q <= pick;
  end

endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int MAG_W  = EXP_W + FRAC_W,
  localparam int WORD_W = MAG_W + 1,
  localparam int N_OPS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_valid,
  input  logic [1:0]        cond_sel,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  input  logic              br_sense,
  output logic              flag,
  output logic              br_take
);

  logic [WORD_W-1:0] op_word [N_OPS];
  opclass_t          op_cls  [N_OPS];
  logic [MAG_W-1:0]  op_mag  [N_OPS];
  logic              eq_w;
  logic              lt_w;
  logic              unord_w;

  assign op_word[0] = opa;
  assign op_word[1] = opb;

  for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) cls_i (
      .word_in (op_word[gi]),
      .cls_out (op_cls[gi]),
      .mag_out (op_mag[gi])
    );
  end

  fcmp_order #(.MAG_W(MAG_W)) ord_i (
    .cls_a  (op_cls[0]),
    .cls_b  (op_cls[1]),
    .mag_a  (op_mag[0]),
    .mag_b  (op_mag[1]),
    .rel_eq (eq_w),
    .rel_lt (lt_w),
    .unord  (unord_w)
  );

  fcmp_flag_reg flg_i (
    .clk     (clk),
    .rst     (rst),
    .load_en (cmp_valid),
    .sel     (cond_sel),
    .rel_eq  (eq_w),
    .rel_lt  (lt_w),
    .flag_q  (flag)
  );

  assign br_take = ~(flag ^ br_sense);

endmodule

// File: rtl/fcmp_flag_chk.sv
module fcmp_flag_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = EXP_W + FRAC_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              cmp_valid,
  input logic [1:0]        cond_sel,
  input logic [WORD_W-1:0] opa,
  input logic [WORD_W-1:0] opb,
  input logic              br_sense,
  input logic              flag,
  input logic              br_take
);

  function automatic logic is_nan(input logic [WORD_W-1:0] w);
    return (&w[WORD_W-2 -: EXP_W]) && (|w[FRAC_W-1:0]);
  endfunction

  function automatic logic is_zeroish(input logic [WORD_W-1:0] w);
    return ~|w[WORD_W-2 -: EXP_W];
  endfunction

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !flag); // R1

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !cmp_valid |=> $stable(flag)); // R2

  AST_RSV_FALSE: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cond_sel == 2'b11) |=> !flag); // R3

  AST_ZERO_EQUAL: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cond_sel == 2'b00 && is_zeroish(opa) && is_zeroish(opb)) |=> flag); // R5

  AST_ZERO_NOT_LESS: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cond_sel == 2'b01 && is_zeroish(opa) && is_zeroish(opb)) |=> !flag); // R6

  AST_NAN_FALSE: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && (is_nan(opa) || is_nan(opb))) |=> !flag); // R7

  AST_SELF_EQUAL: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cond_sel == 2'b00 && opa == opb && !is_nan(opa)) |=> flag); // R4

  AST_BRANCH_READ: assert property (@(posedge clk) disable iff (rst)
    br_take == (br_sense ? flag : !flag)); // R9

endmodule

bind fcmp_flag_unit fcmp_flag_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cmp_valid (cmp_valid),
  .cond_sel  (cond_sel),
  .opa       (opa),
  .opb       (opb),
  .br_sense  (br_sense),
  .flag      (flag),
  .br_take   (br_take)
);

// File: tb/fcmp_flag_unit_tb_top.sv
`timescale 1ns/1ps
module fcmp_flag_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmp_valid;
  logic [1:0]  cond_sel;
  logic [31:0] opa;
  logic [31:0] opb;
  logic        br_sense;
  logic        flag;
  logic        br_take;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  fcmp_flag_unit dut_i (
    .clk       (clk),
    .rst       (rst),
    .cmp_valid (cmp_valid),
    .cond_sel  (cond_sel),
    .opa       (opa),
    .opb       (opb),
    .br_sense  (br_sense),
    .flag      (flag),
    .br_take   (br_take)
  );

  localparam logic [31:0] P1 = 32'h3F800000, P2 = 32'h40000000;
  localparam logic [31:0] N1 = 32'hBF800000, N2 = 32'hC0000000;
  localparam logic [31:0] PZ = 32'h00000000, NZ = 32'h80000000;
  localparam logic [31:0] PI = 32'h7F800000, NI = 32'hFF800000;
  localparam logic [31:0] QN = 32'h7FC00000, SN = 32'h7F800001;
  localparam logic [31:0] PD = 32'h00000001, ND = 32'h80000001;
  localparam logic [31:0] MN = 32'h00800000;
  localparam logic [31:0] PM = 32'h7F7FFFFF, NM = 32'hFF7FFFFF;
  localparam logic [1:0]  EQ = 2'b00, LT = 2'b01, LE = 2'b10, RS = 2'b11;

  localparam int NV = 25;
  // {a, b, select, expected flag, requirement number}
  localparam logic [74:0] VEC [NV] = '{
    {P1, P2, LT, 1'b1, 8'd4},   // R4
    {P2, P1, LT, 1'b0, 8'd4},   // R4
    {P1, P1, EQ, 1'b1, 8'd3},   // R3
    {P1, P1, LE, 1'b1, 8'd3},   // R3
    {P1, P1, LT, 1'b0, 8'd3},   // R3
    {N2, N1, LT, 1'b1, 8'd4},   // R4
    {N1, N2, LT, 1'b0, 8'd4},   // R4
    {N1, P1, LT, 1'b1, 8'd4},   // R4
    {P1, N1, LE, 1'b0, 8'd4},   // R4
    {PZ, NZ, EQ, 1'b1, 8'd5},   // R5
    {NZ, PZ, LT, 1'b0, 8'd5},   // R5
    {NZ, PZ, LE, 1'b1, 8'd5},   // R5
    {PD, PZ, EQ, 1'b1, 8'd6},   // R6
    {ND, PZ, EQ, 1'b1, 8'd6},   // R6
    {PD, MN, LT, 1'b1, 8'd6},   // R6
    {PD, ND, EQ, 1'b1, 8'd6},   // R6
    {QN, QN, EQ, 1'b0, 8'd7},   // R7
    {QN, P1, LT, 1'b0, 8'd7},   // R7
    {P1, QN, LE, 1'b0, 8'd7},   // R7
    {SN, SN, EQ, 1'b0, 8'd7},   // R7
    {PM, PI, LT, 1'b1, 8'd8},   // R8
    {NI, NM, LT, 1'b1, 8'd8},   // R8
    {PI, PI, EQ, 1'b1, 8'd8},   // R8
    {PI, NI, LE, 1'b0, 8'd8},   // R8
    {P1, P2, RS, 1'b0, 8'd3}    // R3
  };

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // drive at negedge, strobe across one rising edge, sample at next negedge
  task automatic do_cmp(input logic [31:0] a, input logic [31:0] b, input logic [1:0] s);
    opa = a; opb = b; cond_sel = s; cmp_valid = 1'b1;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  initial begin
    rst = 1'b1; cmp_valid = 1'b0; cond_sel = EQ;
    opa = '0; opb = '0; br_sense = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", flag, 1'b0);        // R1 reset value
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      do_cmp(VEC[i][74:43], VEC[i][42:11], VEC[i][10:9]);
      check($sformatf("R%0d vec%0d", VEC[i][7:0], i), flag, VEC[i][8]);
    end

    // R2: flag is sticky while the strobe is low
    do_cmp(P1, P2, LT);
    check("R2 set", flag, 1'b1);
    opa = P2; opb = P1; cond_sel = LT; cmp_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 hold-high", flag, 1'b1);
    do_cmp(QN, P1, EQ);
    check("R2 load", flag, 1'b0);
    opa = P1; opb = P1; cond_sel = EQ;
    repeat (2) @(negedge clk);
    check("R2 hold-low", flag, 1'b0);

    // R9: both branch polarities on both flag values
    br_sense = 1'b1; #0.5; check("R9 clear/true", br_take, 1'b0);
    br_sense = 1'b0; #0.5; check("R9 clear/false", br_take, 1'b1);
    @(negedge clk);
    do_cmp(N1, P1, LE);
    br_sense = 1'b1; #0.5; check("R9 set/true", br_take, 1'b1);
    br_sense = 1'b0; #0.5; check("R9 set/false", br_take, 1'b0);

    // R1: reset in the middle of operation clears a set flag
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run", flag, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule